// File: doc/BRIEF.md
# Vector IIR averaging filter

This block is a streaming single-pole recursive filter whose feedback path reaches back a programmable number of samples instead of one. Each output is `y[n] = beta*x[n] + alpha*y[n-D]`. When `D` equals the number of samples in a vector, the feedback only ever pairs samples that sit at the same position in consecutive vectors. Each position is therefore averaged on its own, which is how spectrum bins are smoothed frame after frame.

Samples are 32-bit complex words on a ready/valid stream with an end-of-vector marker. The signed 16-bit I part is in bits 31:16 and the signed 16-bit Q part is in bits 15:0. The same real coefficients act on both parts. The length, the two coefficients and a synchronous clear are plain inputs. Any change to them empties the filter history before the next sample is taken. The block reports the length in force and the largest length it supports, so that control software can find the limit.

Top module: `vec_iir_avg`

## Requirements
- R1: Per 16-bit lane, the output is the sum of two products, each rounded to nearest, saturated to [-32768, 32767]. The first is round(beta*x / 65536) and the second is round(alpha*yd / 65536). Rounding adds 32768 to the product and takes the floor of the quotient. alpha and beta are unsigned 16-bit fractions (value/65536). I is bits 31:16 and Q is bits 15:0.
- R2: yd is the output produced D accepted samples earlier. It is zero for the first D samples after a reset or clear.
- R3: The effective D is cfg_len, except that 0 or any value above MAX_DELAY becomes MAX_DELAY. cur_len shows the effective D in force, and max_len shows MAX_DELAY.
- R4: In any cycle where clr is high, or where cfg_len (after clamping), cfg_alpha or cfg_beta differs from the value in force, in_ready is low. At the next clock edge the new values take effect, the history is emptied and out_valid goes low.
- R5: out_last carries the in_last value that arrived with the same sample.
- R6: While out_valid is high and out_ready is low, out_data and out_last stay unchanged and in_ready is low. No sample is lost or repeated.
- R7: After reset, out_valid is low, in_ready is high and the history is empty.
- R8: A sample accepted at a clock edge appears on out_data with out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous history clear |
| cfg_len | input | LEN_IN_W | Requested feedback delay D |
| cfg_alpha | input | 16 | Feedback coefficient, unsigned fraction |
| cfg_beta | input | 16 | Feedforward coefficient, unsigned fraction |
| in_data | input | 32 | Input sample, I high, Q low |
| in_last | input | 1 | End-of-vector marker on input |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts input |
| out_data | output | 32 | Filtered sample |
| out_last | output | 1 | End-of-vector marker on output |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts output |
| cur_len | output | LEN_W | Effective delay in force |
| max_len | output | LEN_W | Largest supported delay |

## Verification
The bench builds the block with MAX_DELAY = 15 and an 8-bit cfg_len. This keeps the delay line small enough that it wraps many times within each configuration, and it lets both clamp cases (zero and values up to 255) be requested. With full-scale inputs and coefficients near one, the sum saturates in both directions. Random valid and ready patterns, together with mid-stream changes of length, coefficients and clear, exercise the stall, flush and refill paths against an independent history model.

// File: rtl/vec_iir_pkg.sv
package vec_iir_pkg;
  localparam int SAMP_W = 32;
  localparam int LANE_W = 16;
  localparam int COEF_W = 16;
  localparam int LANES  = SAMP_W / LANE_W;

  // product of an unsigned Q0.16 fraction and a signed lane, rounded to nearest
  function automatic logic signed [17:0] scale_round(input logic [COEF_W-1:0] c,
                                                     input logic signed [LANE_W-1:0] v);
    logic signed [33:0] p;
    p = 34'($signed({1'b0, c}) * v);
    p = p + 34'sd32768;
    return p[33:16];
  endfunction

  // clip an 18-bit sum into the signed 16-bit range
  function automatic logic [LANE_W-1:0] sat16(input logic signed [17:0] s);
    if (s > 18'sd32767)       return 16'h7FFF;
    else if (s < -18'sd32768) return 16'h8000;
    else                      return s[15:0];
  endfunction

  function automatic logic [LANE_W-1:0] lane_step(input logic [COEF_W-1:0] b,
                                                  input logic [COEF_W-1:0] a,
                                                  input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] yd);
    logic signed [17:0] sum;
    sum = scale_round(b, $signed(x)) + scale_round(a, $signed(yd));
    return sat16(sum);
  endfunction
endpackage

// File: rtl/vi_cfg.sv
module vi_cfg #(
  parameter int MAX_DELAY = 255,
  parameter int LEN_IN_W  = 16,
  parameter int LEN_W     = 8,
  parameter int COEF_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [LEN_IN_W-1:0] cfg_len,
  input  logic [COEF_W-1:0] cfg_alpha,
  input  logic [COEF_W-1:0] cfg_beta,
  output logic [LEN_W-1:0]  len_q,
  output logic [COEF_W-1:0] alpha_q,
  output logic [COEF_W-1:0] beta_q,
  output logic              dirty
);
  logic [LEN_W-1:0] len_eff;
  logic             out_of_range;

  assign out_of_range = (cfg_len == '0) || (cfg_len > LEN_IN_W'(MAX_DELAY));
  assign len_eff      = out_of_range ? LEN_W'(MAX_DELAY) : LEN_W'(cfg_len);

  assign dirty = clr || (len_eff != len_q) || (cfg_alpha != alpha_q) || (cfg_beta != beta_q);

  always_ff @(posedge clk) begin
    if (rst || dirty) begin
      len_q   <= len_eff;
      alpha_q <= cfg_alpha;
      beta_q  <= cfg_beta;
    end
  end
endmodule

// File: rtl/vi_delay_line.sv
module vi_delay_line #(
  parameter int DEPTH  = 255,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wrap
);
  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [LEN_W-1:0]  ptr;
  logic              primed;

  assign wrap  = adv && (ptr == len - LEN_W'(1));
  assign rdata = primed ? mem[ptr] : '0;

  always_ff @(posedge clk) begin
    if (adv) mem[ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr    <= '0;
      primed <= 1'b0;
    end else if (adv) begin
      if (wrap) begin
        ptr    <= '0;
        primed <= 1'b1;
      end else begin
        ptr <= ptr + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/vi_mac.sv
module vi_mac
  import vec_iir_pkg::*;
(
  input  logic [COEF_W-1:0] alpha,
  input  logic [COEF_W-1:0] beta,
  input  logic [SAMP_W-1:0] x,
  input  logic [SAMP_W-1:0] yd,
  output logic [SAMP_W-1:0] y
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign y[l*LANE_W +: LANE_W] = lane_step(beta, alpha, x[l*LANE_W +: LANE_W],
                                             yd[l*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/vec_iir_avg.sv
module vec_iir_avg
  import vec_iir_pkg::*;
#(
  parameter int MAX_DELAY = 255,
  parameter int LEN_IN_W  = 16,
  localparam int LEN_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [LEN_IN_W-1:0] cfg_len,
  input  logic [15:0]         cfg_alpha,
  input  logic [15:0]         cfg_beta,
  input  logic [31:0]         in_data,
  input  logic                in_last,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [31:0]         out_data,
  output logic                out_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LEN_W-1:0]    cur_len,
  output logic [LEN_W-1:0]    max_len
);
  logic [LEN_W-1:0]  len_q;
  logic [COEF_W-1:0] alpha_q;
  logic [COEF_W-1:0] beta_q;
  logic              cfg_dirty;
  logic              accept;
  logic              wrap;
  logic [SAMP_W-1:0] y_delayed;
  logic [SAMP_W-1:0] y_next;

  vi_cfg #(.MAX_DELAY(MAX_DELAY), .LEN_IN_W(LEN_IN_W), .LEN_W(LEN_W), .COEF_W(COEF_W)) u_cfg (
    .clk(clk), .rst(rst), .clr(clr), .cfg_len(cfg_len), .cfg_alpha(cfg_alpha),
    .cfg_beta(cfg_beta), .len_q(len_q), .alpha_q(alpha_q), .beta_q(beta_q), .dirty(cfg_dirty)
  );

  assign in_ready = !cfg_dirty && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  vi_delay_line #(.DEPTH(MAX_DELAY), .LEN_W(LEN_W), .DATA_W(SAMP_W)) u_dly (
    .clk(clk), .rst(rst), .clear(cfg_dirty), .adv(accept), .len(len_q),
    .wdata(y_next), .rdata(y_delayed), .wrap(wrap)
  );

  vi_mac u_mac (.alpha(alpha_q), .beta(beta_q), .x(in_data), .yd(y_delayed), .y(y_next));

  always_ff @(posedge clk) begin
    if (rst || cfg_dirty) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_last <= 1'b0;
    end else if (accept) begin
      out_data <= y_next;
      out_last <= in_last;
    end
  end

  assign cur_len = len_q;
  assign max_len = LEN_W'(MAX_DELAY);
endmodule

// File: rtl/vec_iir_avg_chk.sv
module vec_iir_avg_chk #(
  parameter int MAX_DELAY = 255,
  parameter int LEN_W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_dirty,
  input logic             accept,
  input logic             wrap,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             out_last,
  input logic [LEN_W-1:0] cur_len
);
  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !cfg_dirty |=> out_valid && $stable(out_data) && $stable(out_last));

  // R6
  ready_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R4
  clear_block_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_dirty |-> !in_ready && !accept);

  // R4
  clear_flush_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_dirty |=> !out_valid);

  // R8
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    cur_len != '0 && cur_len <= LEN_W'(MAX_DELAY));

  // R2
  wrap_accept_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> accept);
endmodule

bind vec_iir_avg vec_iir_avg_chk #(.MAX_DELAY(MAX_DELAY), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_dirty(cfg_dirty), .accept(accept), .wrap(wrap),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .cur_len(cur_len)
);

// File: tb/tb_vec_iir_avg.sv
module tb_vec_iir_avg;
  localparam int MAXD = 15;
  localparam int LIW  = 8;

  logic clk = 1'b0;
  logic rst, clr, in_last, in_valid, out_ready;
  logic [LIW-1:0] cfg_len;
  logic [15:0] cfg_alpha, cfg_beta;
  logic [31:0] in_data;
  logic in_ready, out_last, out_valid;
  logic [31:0] out_data;
  logic [3:0] cur_len, max_len;

  vec_iir_avg #(.MAX_DELAY(MAXD), .LEN_IN_W(LIW)) dut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_len(cfg_len), .cfg_alpha(cfg_alpha),
    .cfg_beta(cfg_beta), .in_data(in_data), .in_last(in_last), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
    .out_ready(out_ready), .cur_len(cur_len), .max_len(max_len)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int m_len, m_a, m_b, n_hist;
  logic [31:0] hist [0:8191];
  logic [32:0] q [0:63];
  int qh = 0, qt = 0;
  bit done = 0;

  function automatic int eff_len(int v);
    return (v == 0 || v > MAXD) ? MAXD : v;
  endfunction

  function automatic int rnd_div(int c, int v);
    longint t = longint'(c) * longint'(v) + 64'sd32768;
    if (t >= 0) return int'(t / 65536);
    return -int'((-t + 65535) / 65536);
  endfunction

  function automatic logic [15:0] lane_ref(int b, int a, int x, int yd);
    int s = rnd_div(b, x) + rnd_div(a, yd);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  function automatic logic [31:0] model(logic [31:0] x);
    logic [31:0] yd = (n_hist >= m_len) ? hist[(n_hist - m_len) % 8192] : 32'h0;
    return {lane_ref(m_b, m_a, int'($signed(x[31:16])), int'($signed(yd[31:16]))),
            lane_ref(m_b, m_a, int'($signed(x[15:0])), int'($signed(yd[15:0])))};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: inputs already driven at the negedge; observe before the posedge
  task automatic step();
    bit dirty;
    logic [31:0] y;
    #5;
    dirty = clr || eff_len(int'(cfg_len)) != m_len || int'(cfg_alpha) != m_a || int'(cfg_beta) != m_b;
    chk(out_valid == (qh != qt), "R6 R8 out_valid", 64'(out_valid), 64'(qh != qt));
    chk(32'(cur_len) == 32'(m_len), "R3 cur_len", 64'(cur_len), 64'(m_len));
    chk(in_ready == (!dirty && (!out_valid || out_ready)), "R4 R6 in_ready",
        64'(in_ready), 64'(!dirty && (!out_valid || out_ready)));
    if (out_valid && out_ready && qh != qt) begin
      chk(out_data == q[qh % 64][31:0], "R1 R2 out_data", 64'(out_data), 64'(q[qh % 64][31:0]));
      chk(out_last == q[qh % 64][32], "R5 out_last", 64'(out_last), 64'(q[qh % 64][32]));
      qh++;
    end
    if (in_valid && in_ready) begin
      y = model(in_data);
      hist[n_hist % 8192] = y;
      n_hist++;
      q[qt % 64] = {in_last, y};
      qt++;
    end
    if (dirty) begin
      qh = qt;
      n_hist = 0;
      m_len = eff_len(int'(cfg_len)); m_a = int'(cfg_alpha); m_b = int'(cfg_beta);
    end
    @(negedge clk);
  endtask

  task automatic run_random(int cycles, int vpct, int rpct, bit big);
    for (int i = 0; i < cycles; i++) begin
      in_valid  = ($urandom % 100) < vpct;
      out_ready = ($urandom % 100) < rpct;
      in_last   = ($urandom % 5) == 0;
      in_data   = big ? (($urandom % 2) ? 32'h7FFF8000 : 32'h80007FFF) : $urandom;
      clr = 1'b0;
      step();
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; clr = 0; in_valid = 0; in_last = 0; in_data = 0; out_ready = 1;
    cfg_len = 8'd3; cfg_alpha = 16'h8000; cfg_beta = 16'h8000;
    m_len = 3; m_a = 32'h8000; m_b = 32'h8000; n_hist = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #5;
    // R7 reset state
    chk(out_valid == 1'b0, "R7 out_valid after reset", 64'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 in_ready after reset", 64'(in_ready), 1);
    chk(max_len == 4'd15, "R3 max_len", 64'(max_len), 15);
    chk(cur_len == 4'd3, "R3 cur_len D=3", 64'(cur_len), 3);
    @(negedge clk);
    // directed: D=3, half coefficients, steady ready (R8 latency via queue)
    for (int i = 0; i < 12; i++) begin
      in_valid = 1; out_ready = 1; in_last = (i % 3) == 2; in_data = {16'(1000 * i), 16'(-500 * i)};
      step();
    end
    // R3 clamp: zero and above maximum
    cfg_len = 8'd0; in_valid = 0; step();
    chk(cur_len == 4'd15, "R3 clamp zero", 64'(cur_len), 15);
    cfg_len = 8'd200; step();
    chk(cur_len == 4'd15, "R3 clamp high", 64'(cur_len), 15);
    run_random(300, 70, 60, 0);
    // R4 change while output is stalled
    cfg_len = 8'd5; in_valid = 1; out_ready = 0; in_data = 32'h12345678; step();
    step();
    cfg_alpha = 16'hC000; out_ready = 0; step();
    chk(out_valid == 1'b0, "R4 flush on alpha change", 64'(out_valid), 0);
    run_random(400, 80, 50, 0);
    // R4 explicit clear mid-stream
    for (int k = 0; k < 6; k++) begin
      run_random(50, 90, 70, 0);
      clr = 1; step(); clr = 0;
    end
    // R1 saturation: coefficients near one, full-scale inputs
    cfg_alpha = 16'hFFFF; cfg_beta = 16'hFFFF; cfg_len = 8'd1;
    run_random(300, 90, 90, 1);
    cfg_len = 8'd15;
    run_random(300, 60, 40, 1);
    // random configurations
    for (int k = 0; k < 20; k++) begin
      cfg_len = 8'($urandom % 24); cfg_alpha = 16'($urandom); cfg_beta = 16'($urandom);
      run_random(200, 1 + $urandom % 100, 1 + $urandom % 100, ($urandom % 4) == 0);
    end
    // drain
    in_valid = 0; out_ready = 1;
    repeat (4) step();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule